// File: doc/BRIEF.md
# Scatter-Gather Descriptor Table Walker

This block steps through a table of region descriptors held in memory on behalf of a disk bus-master DMA channel. Every descriptor takes eight bytes. The low 32-bit word is the start address of a memory region. The high 32-bit word is a control word that carries an even byte count and an end-of-table bit. The walker reads descriptors one at a time over a read port with a request/response handshake. From each region it cuts transfer requests for an external data mover. Each request is as large as the smaller of two amounts: the bytes the job still needs, and the bytes left in the current region.

A controller drives the walker. While the walker is idle, the controller may reload the descriptor pointer from the table base, clear the current region, or both. It then launches a job with a byte count and a mode. In move mode the walk stops as soon as the byte count is met, and any unused part of the current region is kept for the next job. In prepare mode the walker stops issuing requests once the byte count is reached. It still reads the rest of the table and totals every byte the table describes. A walk ends in one of two ways: a done pulse, or a short pulse when the table runs out first. The table runs out either at its last descriptor or when the pointer has moved one page past the base.

Top module: `sg_table_walker`

## Requirements
- R1: After reset the walker is idle. `jobReady` is 1, and `fetchValid`, `xferValid`, `donePulse` and `shortPulse` are 0.
- R2: A descriptor read is issued at the current pointer, and the pointer then advances by 8. The response carries the region address in bits 31:0 and the control word in bits 63:32. Bits 1:0 of `tableBase` are ignored.
- R3: The region length is control bits 15:1 with bit 0 forced to zero. Bit 0 and bits 30:16 have no effect.
- R4: A decoded length of zero gives a region of 65536 bytes.
- R5: Control bit 31 marks the last descriptor. Once that region is used up, the walker reads no further descriptor.
- R6: Once the region is used up and the pointer is 4096 or more bytes past the table base, the walker ends the walk without a further read.
- R7: In move mode each request is min(job bytes still needed, region bytes left). Its address is the current region address. Region address and remaining count then move by that amount.
- R8: In move mode, `donePulse` fires once the requested bytes equal the job size. Any unused part of the current region is kept, and the next job continues from it.
- R9: In prepare mode, requests stop at the job size. Every remaining region is still consumed, and `describedBytes` ends at the total length the table describes.
- R10: When the table ends before the job is met, `shortPulse` fires instead of `donePulse`. In prepare mode, `donePulse` fires at table end if the requests reached the job size.
- R11: `cmdRestart` reloads the pointer from the table base. `cmdStart` clears the current region and the last flag. Without `cmdStart`, a used-up last region ends the next job with no read.
- R12: After a read request is accepted, the walker issues no request of either kind until the response arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tableBase | input | 32 | Table base address (bits 1:0 ignored) |
| cmdStart | input | 1 | Clear the current region (acted on while idle) |
| cmdRestart | input | 1 | Reload the pointer from the base (acted on while idle) |
| jobValid | input | 1 | Launch a job (taken while idle) |
| jobReady | output | 1 | Walker is idle |
| jobBytes | input | 24 | Job byte count |
| jobPrep | input | 1 | 1 = prepare mode, 0 = move mode |
| fetchValid | output | 1 | Descriptor read request |
| fetchReady | input | 1 | Read request accepted |
| fetchAddr | output | 32 | Descriptor address |
| respValid | input | 1 | Descriptor data returned |
| respData | input | 64 | Descriptor: {control, address} |
| xferValid | output | 1 | Transfer request to the data mover |
| xferReady | input | 1 | Transfer request accepted |
| xferAddr | output | 32 | Transfer start address |
| xferLen | output | 17 | Transfer byte count |
| donePulse | output | 1 | Job satisfied (one cycle) |
| shortPulse | output | 1 | Table ended first (one cycle) |
| describedBytes | output | 32 | Bytes consumed from regions in this job |

## Verification
Directed tables cover four cases. The first has three regions, one with an odd control count, which shows the even masking and the min sizing. A follow-on job with no commands shows that the leftover region carries over. A zero count shows the 64 KiB case, and a long table with no last bit shows the page bound. Prepare mode runs against a table that describes more bytes than the job. That separates the capped requests from the described total. Randomized tables mix odd counts, zero counts, a random last position and random command choices. This exercises the interplay between commands, carry-over and both end conditions. Random ready and response delays test that requests hold steady and that the walker waits for each read response.

// File: rtl/sgw_pkg.sv
package sgw_pkg;

  localparam int WORD_W       = 32;
  localparam int DESC_W       = 2 * WORD_W;
  localparam int REGION_LEN_W = 17;

  typedef enum logic [2:0] {
    S_IDLE,
    S_DECIDE,
    S_FETCH_REQ,
    S_FETCH_WAIT,
    S_XFER
  } sgwState_t;

  typedef struct packed {
    logic clrRegion;
    logic loadPtr;
    logic loadJob;
    logic loadDesc;
    logic consume;
  } sgwStrobes_t;

  typedef struct packed {
    logic regionEmpty;
    logic tableEnd;
    logic needMet;
    logic takeZero;
    logic prep;
  } sgwStatus_t;

  // Region length from a control word: bits 15:1, even, zero means 64 KiB.
  function automatic logic [REGION_LEN_W-1:0] decodeLen(input logic [WORD_W-1:0] ctl);
    logic [15:0] evenLen;
    evenLen = {ctl[15:1], 1'b0};
    if (evenLen == 16'd0) return REGION_LEN_W'(17'h10000);
    return REGION_LEN_W'(evenLen);
  endfunction

  function automatic logic decodeLast(input logic [WORD_W-1:0] ctl);
    return ctl[WORD_W-1];
  endfunction

endpackage

// File: rtl/sgw_datapath.sv
module sgw_datapath
  import sgw_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int NEED_W     = 24,
  parameter int CNT_W      = 32,
  parameter int PAGE_BYTES = 4096,
  parameter int DESC_BYTES = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  sgwStrobes_t             strb,
  input  logic [ADDR_W-1:0]       tableBase,
  input  logic [NEED_W-1:0]       jobBytes,
  input  logic                    jobPrep,
  input  logic [DESC_W-1:0]       respData,
  output sgwStatus_t              stat,
  output logic [ADDR_W-1:0]       fetchAddr,
  output logic [ADDR_W-1:0]       xferAddr,
  output logic [REGION_LEN_W-1:0] xferLen,
  output logic [CNT_W-1:0]        describedBytes
);

  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(3);
  localparam logic [ADDR_W-1:0] PAGE_LIM   = ADDR_W'(PAGE_BYTES);
  localparam logic [ADDR_W-1:0] DESC_STEP  = ADDR_W'(DESC_BYTES);

  logic [ADDR_W-1:0]       ptrQ, regAddrQ;
  logic [REGION_LEN_W-1:0] regLenQ;
  logic                    regLastQ;
  logic [NEED_W-1:0]       needQ, issuedQ;
  logic                    prepQ;
  logic [CNT_W-1:0]        descQ;

  logic [ADDR_W-1:0]       baseAligned, ptrOffset;
  logic [NEED_W-1:0]       needLeft;
  logic [REGION_LEN_W-1:0] takeLen, consumeLen;
  logic [WORD_W-1:0]       ctlWord;

  assign baseAligned = tableBase & ALIGN_MASK;
  assign ptrOffset   = ptrQ - baseAligned;
  assign needLeft    = needQ - issuedQ;
  assign ctlWord     = respData[DESC_W-1:WORD_W];

  always_comb begin
    if (CNT_W'(needLeft) < CNT_W'(regLenQ)) takeLen = REGION_LEN_W'(needLeft);
    else                                    takeLen = regLenQ;
    consumeLen = prepQ ? regLenQ : takeLen;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptrQ     <= '0;
      regAddrQ <= '0;
      regLenQ  <= '0;
      regLastQ <= 1'b0;
      needQ    <= '0;
      issuedQ  <= '0;
      prepQ    <= 1'b0;
      descQ    <= '0;
    end else begin
      if (strb.loadPtr) ptrQ <= baseAligned;
      if (strb.clrRegion) begin
        regAddrQ <= '0;
        regLenQ  <= '0;
        regLastQ <= 1'b0;
      end
      if (strb.loadJob) begin
        needQ   <= jobBytes;
        prepQ   <= jobPrep;
        issuedQ <= '0;
        descQ   <= '0;
      end
      if (strb.loadDesc) begin
        regAddrQ <= respData[WORD_W-1:0];
        regLenQ  <= decodeLen(ctlWord);
        regLastQ <= decodeLast(ctlWord);
        ptrQ     <= ptrQ + DESC_STEP;
      end
      if (strb.consume) begin
        issuedQ  <= issuedQ + NEED_W'(takeLen);
        regAddrQ <= regAddrQ + ADDR_W'(consumeLen);
        regLenQ  <= regLenQ - consumeLen;
        descQ    <= descQ + CNT_W'(consumeLen);
      end
    end
  end

  assign stat.regionEmpty = (regLenQ == '0);
  assign stat.tableEnd    = regLastQ || (ptrOffset >= PAGE_LIM);
  assign stat.needMet     = (issuedQ == needQ);
  assign stat.takeZero    = (takeLen == '0);
  assign stat.prep        = prepQ;

  assign fetchAddr      = ptrQ;
  assign xferAddr       = regAddrQ;
  assign xferLen        = takeLen;
  assign describedBytes = descQ;

endmodule

// File: rtl/sgw_ctrl.sv
module sgw_ctrl
  import sgw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmdStart,
  input  logic        cmdRestart,
  input  logic        jobValid,
  input  logic        fetchReady,
  input  logic        respValid,
  input  logic        xferReady,
  input  sgwStatus_t  stat,
  output sgwStrobes_t strb,
  output logic        jobReady,
  output logic        fetchValid,
  output logic        xferValid,
  output logic        donePulse,
  output logic        shortPulse
);

  sgwState_t stateQ, stateD;

  always_ff @(posedge clk) begin
    if (!rst_n) stateQ <= S_IDLE;
    else        stateQ <= stateD;
  end

  always_comb begin
    stateD     = stateQ;
    strb       = '0;
    jobReady   = 1'b0;
    fetchValid = 1'b0;
    xferValid  = 1'b0;
    donePulse  = 1'b0;
    shortPulse = 1'b0;
    case (stateQ)
      S_IDLE: begin
        jobReady       = 1'b1;
        strb.clrRegion = cmdStart;
        strb.loadPtr   = cmdRestart;
        strb.loadJob   = jobValid;
        if (jobValid) stateD = S_DECIDE;
      end
      S_DECIDE: begin
        if (!stat.prep && stat.needMet) begin
          donePulse = 1'b1;
          stateD    = S_IDLE;
        end else if (stat.regionEmpty) begin
          if (stat.tableEnd) begin
            if (stat.prep && stat.needMet) donePulse  = 1'b1;
            else                           shortPulse = 1'b1;
            stateD = S_IDLE;
          end else begin
            stateD = S_FETCH_REQ;
          end
        end else if (stat.takeZero) begin
          strb.consume = 1'b1;
        end else begin
          stateD = S_XFER;
        end
      end
      S_FETCH_REQ: begin
        fetchValid = 1'b1;
        if (fetchReady) stateD = S_FETCH_WAIT;
      end
      S_FETCH_WAIT: begin
        if (respValid) begin
          strb.loadDesc = 1'b1;
          stateD        = S_DECIDE;
        end
      end
      S_XFER: begin
        xferValid = 1'b1;
        if (xferReady) begin
          strb.consume = 1'b1;
          stateD       = S_DECIDE;
        end
      end
      default: stateD = S_IDLE;
    endcase
  end

endmodule

// File: rtl/sg_table_walker.sv
module sg_table_walker
  import sgw_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int NEED_W     = 24,
  parameter int CNT_W      = 32,
  parameter int PAGE_BYTES = 4096,
  parameter int DESC_BYTES = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       tableBase,
  input  logic                    cmdStart,
  input  logic                    cmdRestart,
  input  logic                    jobValid,
  output logic                    jobReady,
  input  logic [NEED_W-1:0]       jobBytes,
  input  logic                    jobPrep,
  output logic                    fetchValid,
  input  logic                    fetchReady,
  output logic [ADDR_W-1:0]       fetchAddr,
  input  logic                    respValid,
  input  logic [DESC_W-1:0]       respData,
  output logic                    xferValid,
  input  logic                    xferReady,
  output logic [ADDR_W-1:0]       xferAddr,
  output logic [REGION_LEN_W-1:0] xferLen,
  output logic                    donePulse,
  output logic                    shortPulse,
  output logic [CNT_W-1:0]        describedBytes
);

  sgwStrobes_t strb;
  sgwStatus_t  stat;

  sgw_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmdStart   (cmdStart),
    .cmdRestart (cmdRestart),
    .jobValid   (jobValid),
    .fetchReady (fetchReady),
    .respValid  (respValid),
    .xferReady  (xferReady),
    .stat       (stat),
    .strb       (strb),
    .jobReady   (jobReady),
    .fetchValid (fetchValid),
    .xferValid  (xferValid),
    .donePulse  (donePulse),
    .shortPulse (shortPulse)
  );

  sgw_datapath #(
    .ADDR_W     (ADDR_W),
    .NEED_W     (NEED_W),
    .CNT_W      (CNT_W),
    .PAGE_BYTES (PAGE_BYTES),
    .DESC_BYTES (DESC_BYTES)
  ) u_dp (
    .clk            (clk),
    .rst_n          (rst_n),
    .strb           (strb),
    .tableBase      (tableBase),
    .jobBytes       (jobBytes),
    .jobPrep        (jobPrep),
    .respData       (respData),
    .stat           (stat),
    .fetchAddr      (fetchAddr),
    .xferAddr       (xferAddr),
    .xferLen        (xferLen),
    .describedBytes (describedBytes)
  );

endmodule

// File: rtl/sgw_checker.sv
module sgw_checker
  import sgw_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    fetchValid,
  input logic                    fetchReady,
  input logic [ADDR_W-1:0]       fetchAddr,
  input logic                    xferValid,
  input logic                    xferReady,
  input logic [ADDR_W-1:0]       xferAddr,
  input logic [REGION_LEN_W-1:0] xferLen,
  input logic                    jobReady,
  input logic                    donePulse,
  input logic                    shortPulse
);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    jobReady |-> !fetchValid && !xferValid);

  p_fetch_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fetchValid |-> fetchAddr[1:0] == 2'b00);

  p_fetch_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fetchValid && !fetchReady |=> fetchValid && $stable(fetchAddr));

  p_len_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    xferValid |-> xferLen != '0 && xferLen <= REGION_LEN_W'(17'h10000));

  p_xfer_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    xferValid && !xferReady |=> xferValid && $stable(xferAddr) && $stable(xferLen));

  p_end_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(donePulse && shortPulse));

  p_end_to_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    donePulse || shortPulse |=> jobReady);

  p_wait_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    fetchValid && fetchReady |=> !fetchValid && !xferValid);

  p_one_request_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fetchValid, xferValid, jobReady}));

endmodule

bind sg_table_walker sgw_checker #(.ADDR_W(ADDR_W)) u_sgw_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .fetchValid (fetchValid),
  .fetchReady (fetchReady),
  .fetchAddr  (fetchAddr),
  .xferValid  (xferValid),
  .xferReady  (xferReady),
  .xferAddr   (xferAddr),
  .xferLen    (xferLen),
  .jobReady   (jobReady),
  .donePulse  (donePulse),
  .shortPulse (shortPulse)
);

// File: tb/sg_table_walker_bench.sv
module sg_table_walker_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] tableBase = 32'h0001_0000;
  logic        cmdStart = 1'b0, cmdRestart = 1'b0, jobValid = 1'b0, jobPrep = 1'b0;
  logic [23:0] jobBytes = '0;
  logic        jobReady, fetchValid, xferValid, donePulse, shortPulse;
  logic        fetchReady = 1'b0, respValid = 1'b0, xferReady = 1'b0;
  logic [31:0] fetchAddr, xferAddr, describedBytes;
  logic [63:0] respData = '0;
  logic [16:0] xferLen;

  always #4 clk = ~clk;

  sg_table_walker u_sg_table_walker (
    .clk(clk), .rst_n(rst_n), .tableBase(tableBase), .cmdStart(cmdStart),
    .cmdRestart(cmdRestart), .jobValid(jobValid), .jobReady(jobReady),
    .jobBytes(jobBytes), .jobPrep(jobPrep), .fetchValid(fetchValid),
    .fetchReady(fetchReady), .fetchAddr(fetchAddr), .respValid(respValid),
    .respData(respData), .xferValid(xferValid), .xferReady(xferReady),
    .xferAddr(xferAddr), .xferLen(xferLen), .donePulse(donePulse),
    .shortPulse(shortPulse), .describedBytes(describedBytes)
  );

  int errors = 0, checks = 0;
  logic [31:0] tAddr [16];
  logic [31:0] tCtl  [16];
  logic [31:0] fillCtl = 32'h2;

  // bench model state
  logic [31:0] mPtr = '0, mRegAddr = '0, mRegLen = '0;
  logic        mLast = 1'b0;
  logic [31:0] expA [64];
  logic [31:0] expL [64];
  int          expN, expFetch, expOut;
  logic [31:0] expDesc, expFirst;

  // observed
  logic [31:0] gotA [64];
  logic [31:0] gotL [64];
  int          gotN = 0, gotFetch = 0, gotOut;
  logic [31:0] gotFirst = '0;
  logic        respPending = 1'b0;
  int          respDelay = 0;
  logic [63:0] respHold = '0;
  int          waitViolations = 0;

  function automatic logic [31:0] baseOf();
    return tableBase & ~32'h3;
  endfunction

  function automatic logic [31:0] memAddr(input logic [31:0] idx);
    if (idx < 16) return tAddr[idx[3:0]];
    return 32'h9000_0000 + (idx << 6);
  endfunction

  function automatic logic [31:0] memCtl(input logic [31:0] idx);
    if (idx < 16) return tCtl[idx[3:0]];
    return fillCtl;
  endfunction

  task automatic check(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic modelJob(input logic st, input logic rs, input logic [31:0] need, input logic prep);
    logic [31:0] issued, take, cons, idx, c, l;
    if (rs) mPtr = baseOf();
    if (st) begin mRegAddr = 0; mRegLen = 0; mLast = 0; end
    issued = 0; expN = 0; expFetch = 0; expDesc = 0; expFirst = 0;
    forever begin
      if (!prep && issued == need) begin expOut = 1; break; end
      if (mRegLen == 0) begin
        if (mLast || (mPtr - baseOf()) >= 32'd4096) begin
          expOut = (prep && issued == need) ? 1 : 2;
          break;
        end
        idx = (mPtr - baseOf()) >> 3;
        if (expFetch == 0) expFirst = mPtr;
        c = memCtl(idx);
        l = c & 32'hFFFE;
        if (l == 0) l = 32'h10000;
        mRegAddr = memAddr(idx); mRegLen = l; mLast = c[31];
        mPtr = mPtr + 8; expFetch++;
      end else begin
        take = (need - issued < mRegLen) ? need - issued : mRegLen;
        cons = prep ? mRegLen : take;
        if (take != 0) begin
          if (expN < 64) begin expA[expN] = mRegAddr; expL[expN] = take; end
          expN++;
        end
        issued += take; mRegAddr += cons; mRegLen -= cons; expDesc += cons;
      end
    end
  endtask

  // responder: drives ready/response at negedge, records handshakes
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        respValid = 1'b0;
        if (respPending) begin
          if (fetchValid || xferValid) waitViolations++;
          if (respDelay == 0) begin
            respValid = 1'b1; respData = respHold; respPending = 1'b0;
          end else respDelay--;
        end
        fetchReady = ($urandom % 4) != 0;
        if (fetchValid && fetchReady) begin
          if (gotFetch == 0) gotFirst = fetchAddr;
          gotFetch++;
          respHold = {memCtl((fetchAddr - baseOf()) >> 3), memAddr((fetchAddr - baseOf()) >> 3)};
          respPending = 1'b1;
          respDelay = $urandom % 3;
        end
        xferReady = ($urandom % 3) != 0;
        if (xferValid && xferReady) begin
          if (gotN < 64) begin gotA[gotN] = xferAddr; gotL[gotN] = 32'(xferLen); end
          gotN++;
        end
      end
    end
  end

  task automatic runJob(input logic st, input logic rs, input logic [31:0] need,
                        input logic prep, input string req);
    int guard;
    int firstBad;
    modelJob(st, rs, need, prep);
    @(negedge clk);
    gotN = 0; gotFetch = 0; gotFirst = 0;
    cmdStart = st; cmdRestart = rs; jobValid = 1'b1; jobBytes = need[23:0]; jobPrep = prep;
    @(negedge clk);
    cmdStart = 0; cmdRestart = 0; jobValid = 0;
    gotOut = 0; guard = 0;
    while (gotOut == 0 && guard < 50000) begin
      if (donePulse) gotOut = 1;
      else if (shortPulse) gotOut = 2;
      else begin @(negedge clk); guard++; end
    end
    check(gotOut == expOut, req, "outcome(1=done,2=short)", gotOut, expOut);
    check(gotN == expN, req, "request count", gotN, expN);
    firstBad = -1;
    for (int i = 0; i < 64; i++)
      if (i < expN && firstBad < 0 && (gotA[i] != expA[i] || gotL[i] != expL[i])) firstBad = i;
    check(firstBad < 0, req, "request list", firstBad < 0 ? 0 : gotL[firstBad],
          firstBad < 0 ? 0 : expL[firstBad]);
    check(gotFetch == expFetch, req, "descriptor reads", gotFetch, expFetch);
    if (expFetch > 0) check(gotFirst == expFirst, req, "first read address", gotFirst, expFirst);
    check(describedBytes == expDesc, req, "described bytes", describedBytes, expDesc);
  endtask

  initial begin
    #(8 * 190000);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 16; i++) begin tAddr[i] = 32'h5000_0000 + i * 32'h1_0000; tCtl[i] = 32'h2; end
    repeat (3) @(negedge clk);
    // R1: reset state
    check(jobReady == 1, "R1", "jobReady", 32'(jobReady), 1);
    check(!fetchValid && !xferValid, "R1", "requests idle", {30'd0, fetchValid, xferValid}, 0);
    check(!donePulse && !shortPulse, "R1", "pulses low", {30'd0, donePulse, shortPulse}, 0);
    rst_n = 1'b1;

    // R3, R7: three regions, odd count masked to even
    tAddr[0] = 32'h2000_0000; tCtl[0] = 32'h0000_0100;
    tAddr[1] = 32'h3000_0000; tCtl[1] = 32'h0000_0301;
    tAddr[2] = 32'h4000_0000; tCtl[2] = 32'h8000_0000;
    runJob(1, 1, 32'h500, 0, "R7");
    check(gotL[1] == 32'h300, "R3", "odd count masked", gotL[1], 32'h300);
    // R8: leftover region carried into the next job
    runJob(0, 0, 32'h200, 0, "R8");
    check(gotA[0] == 32'h4000_0100, "R8", "carried address", gotA[0], 32'h4000_0100);
    // R5, R10: last bit on descriptor 1 ends before the job is met
    tCtl[1] = 32'h8000_0301;
    runJob(1, 1, 32'h1000, 0, "R10");
    check(gotOut == 2 && gotFetch == 2, "R5", "stop at last", gotFetch, 2);
    // R9: prepare mode caps requests, consumes whole table
    tCtl[0] = 32'h100; tCtl[1] = 32'h100; tCtl[2] = 32'h8000_0100;
    runJob(1, 1, 32'h150, 1, "R9");
    check(describedBytes == 32'h300, "R9", "described total", describedBytes, 32'h300);
    // R11: no start -> used-up last region ends with no read; then restart from base
    tableBase = 32'h0001_0003;
    runJob(0, 1, 32'h10, 0, "R11");
    check(gotFetch == 0 && gotOut == 2, "R11", "no start no read", gotFetch, 0);
    runJob(1, 1, 32'h10, 0, "R11");
    check(gotFirst == 32'h0001_0000, "R2", "base low bits ignored", gotFirst, 32'h0001_0000);
    tableBase = 32'h0001_0000;
    // R4: zero count gives 64 KiB, bit 0 ignored
    tAddr[0] = 32'h6000_0000; tCtl[0] = 32'h8000_0001;
    runJob(1, 1, 32'h20000, 0, "R4");
    check(gotL[0] == 32'h10000, "R4", "zero count length", gotL[0], 32'h10000);
    // R6: one-page bound with no last bit anywhere
    for (int i = 0; i < 16; i++) tCtl[i] = 32'h2;
    fillCtl = 32'h2;
    runJob(1, 1, 32'h10_0000, 0, "R6");
    check(gotFetch == 512, "R6", "reads before page bound", gotFetch, 512);

    // randomized tables, commands and modes
    for (int j = 0; j < 40; j++) begin
      int lastIdx;
      lastIdx = $urandom % 20;
      for (int i = 0; i < 16; i++) begin
        tAddr[i] = $urandom & 32'hFFFF_FFF0;
        if ($urandom % 8 == 0) tCtl[i] = $urandom % 2;
        else tCtl[i] = ($urandom & 32'h7FFF_03FF) | 32'h4;
        tCtl[i][31] = (i == lastIdx);
      end
      runJob(($urandom % 4) != 0, ($urandom % 4) != 0,
             ($urandom % 3 == 0) ? ($urandom % 32'h40000) : ($urandom % 32'h800),
             $urandom % 2, ($urandom % 2) ? "R7" : "R9");
    end

    check(waitViolations == 0, "R12", "request during read wait", waitViolations, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule